// File: doc/BRIEF.md
# Bridge Output-Stage Fault Protection Controller

This controller sits between the two PWM streams of a bridge-tied load (side A and side B) and the four gate-enable lines of the output stage. Each side has a high-side and a low-side line. In normal operation each side's high-side enable follows its PWM input, and the low-side enable is the complement. Dead time, level shifting and drive strength belong to later stages.

Four digitized fault flags arrive from analog detectors: supply undervoltage, over-temperature, over-current and a forced-mute request. An active-low enable/clear line also comes in. Each fault class has its own override and its own release policy.

- **Undervoltage** clamps both outputs low. It never reports and recovers by itself.
- **Over-temperature, over-current and mute** switch every transistor off and float both outputs. They pull the open-drain fault line low and stay latched until software clears them. The clear is a falling edge on the enable line, taken once the condition has gone away.

Every recovery waits for the first rising PWM edge on either side. Fault entry acts at once and does not wait for a clock edge or a PWM edge. Release decisions use synchronized copies of the flags.

Top module: `bridge_guard`

## Requirements
- R1: After reset, with no fault flag raised, the block is in normal switching. For each side i, gate_hi[i] equals pwm_in[i] and gate_lo[i] equals its complement, three clock edges after the input changes. In this state flt_n is 1 and hiz is 0.
- R2: While uv_flag is 1, and no other-class fault is active, the outputs are clamped low: gate_hi is all 0 and gate_lo is all 1. In this state hiz stays 0 and flt_n stays 1. The clamp takes effect combinationally in the same cycle and ignores PWM activity.
- R3: After uv_flag returns to 0, the low clamp stays in place until a rising edge of either PWM input is seen after the synchronized flag has cleared. Normal switching resumes on that edge.
- R4: When ot_flag or oc_flag is 1, gate_hi and gate_lo are all 0, hiz is all 1 and flt_n is 0. This happens combinationally in the same cycle.
- R5: An over-temperature or over-current event is latched. The float and flt_n=0 persist after the flag clears, for as long as en_n stays high.
- R6: A falling edge on en_n while a latched-class flag is still active (after synchronization) has no effect. The state remains latched, and a later clear needs a new falling edge.
- R7: A falling edge on en_n after all latched-class flags have cleared returns flt_n to 1 within four clock edges. The outputs keep floating (hiz all 1, all gates 0) until a PWM rising edge.
- R8: From the cleared state, normal switching resumes on the first rising edge of either PWM input. PWM edges that occurred before the clear, and a PWM input that is already high at the clear, do not resume switching.
- R9: When undervoltage and a latched-class fault are both active, the all-off float has priority. Undervoltage recovery does not release a pending latched fault. A latched fault released while undervoltage persists leaves the low clamp in force.
- R10: mute_req behaves as a latched-class fault (float, flt_n=0). An en_n falling edge while mute_req is still 1 does not cancel it. Cancelling requires mute_req to drop first, then an en_n falling edge, then a PWM rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | SIDES | PWM input per side (bit 0 = side A, bit 1 = side B) |
| uv_flag | input | 1 | Supply undervoltage flag, active high |
| ot_flag | input | 1 | Over-temperature flag, active high, hysteresis applied upstream |
| oc_flag | input | 1 | Over-current flag, active high |
| mute_req | input | 1 | Forced-mute request, active high |
| en_n | input | 1 | Active-low enable/clear; its falling edge clears a latched fault |
| gate_hi | output | SIDES | High-side gate enable per side |
| gate_lo | output | SIDES | Low-side gate enable per side |
| hiz | output | SIDES | 1 when the side's output is floated (both transistors off) |
| flt_n | output | 1 | Fault notification, 0 = pull the open-drain line low |

## Verification
The bench builds the block with its defaults: two sides and two synchronizer stages. With these values, every release path settles within a handful of cycles. Short clear pulses of six cycles therefore exercise the edge detection on the enable line, and PWM edges placed just before and just after a clear show the arming rule. The two-sided build lets one scenario resume on side A and another on side B, covering the either-side rule. It also makes the undervoltage and latched-class overlap observable on both outputs at once.

// File: rtl/bridge_guard_pkg.sv
package bridge_guard_pkg;

  typedef enum logic [1:0] {
    LAT_IDLE  = 2'd0,
    LAT_HELD  = 2'd1,
    LAT_ARMED = 2'd2
  } lat_state_t;

  typedef enum logic [1:0] {
    UV_OK    = 2'd0,
    UV_LOW   = 2'd1,
    UV_ARMED = 2'd2
  } uv_state_t;

endpackage

// File: rtl/bg_sync.sv
module bg_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/bg_rise.sv
module bg_rise #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic         rise_any
);

  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= lvl;
  end

  assign rise_any = |(lvl & ~prev);

endmodule

// File: rtl/bg_latch_ctl.sv
module bg_latch_ctl
  import bridge_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cond_s,
  input  logic       en_fall,
  input  logic       pwm_rise,
  output lat_state_t st
);

  lat_state_t nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      LAT_IDLE:  if (cond_s) nxt = LAT_HELD;
      LAT_HELD:  if (!cond_s && en_fall) nxt = LAT_ARMED;
      LAT_ARMED: begin
        if (cond_s)        nxt = LAT_HELD;
        else if (pwm_rise) nxt = LAT_IDLE;
      end
      default:   nxt = LAT_HELD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= LAT_IDLE;
    else     st <= nxt;
  end

endmodule

// File: rtl/bg_uv_ctl.sv
module bg_uv_ctl
  import bridge_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      uv_s,
  input  logic      pwm_rise,
  output uv_state_t st
);

  uv_state_t nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      UV_OK:    if (uv_s) nxt = UV_LOW;
      UV_LOW:   if (!uv_s) nxt = UV_ARMED;
      UV_ARMED: begin
        if (uv_s)          nxt = UV_LOW;
        else if (pwm_rise) nxt = UV_OK;
      end
      default:  nxt = UV_LOW;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= UV_OK;
    else     st <= nxt;
  end

endmodule

// File: rtl/bg_outstage.sv
module bg_outstage #(
  parameter int SIDES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SIDES-1:0] pwm_s,
  input  logic             off_ov,
  input  logic             uv_ov,
  output logic [SIDES-1:0] gate_hi,
  output logic [SIDES-1:0] gate_lo,
  output logic [SIDES-1:0] hiz
);

  logic [SIDES-1:0] nrm_hi;

  always_ff @(posedge clk) begin
    if (rst) nrm_hi <= '0;
    else     nrm_hi <= pwm_s;
  end

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    always_comb begin
      if (off_ov) begin
        gate_hi[s] = 1'b0;
        gate_lo[s] = 1'b0;
        hiz[s]     = 1'b1;
      end else if (uv_ov) begin
        gate_hi[s] = 1'b0;
        gate_lo[s] = 1'b1;
        hiz[s]     = 1'b0;
      end else begin
        gate_hi[s] = nrm_hi[s];
        gate_lo[s] = ~nrm_hi[s];
        hiz[s]     = 1'b0;
      end
    end
  end

endmodule

// File: rtl/bridge_guard.sv
module bridge_guard
  import bridge_guard_pkg::*;
#(
  parameter int SIDES = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SIDES-1:0] pwm_in,
  input  logic             uv_flag,
  input  logic             ot_flag,
  input  logic             oc_flag,
  input  logic             mute_req,
  input  logic             en_n,
  output logic [SIDES-1:0] gate_hi,
  output logic [SIDES-1:0] gate_lo,
  output logic [SIDES-1:0] hiz,
  output logic             flt_n
);

  localparam int NFLAG = 4;

  logic [SIDES-1:0] pwm_s;
  logic [NFLAG-1:0] flag_s;
  logic             en_s;
  logic             pwm_rise;
  logic             en_fall;
  logic             lat_raw;
  logic             off_ov;
  logic             uv_ov;
  lat_state_t       lat_st;
  uv_state_t        uv_st;

  bg_sync #(.W(SIDES), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_pwm (
    .clk(clk), .rst(rst), .d(pwm_in), .q(pwm_s)
  );

  bg_sync #(.W(NFLAG), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_flag (
    .clk(clk), .rst(rst), .d({mute_req, oc_flag, ot_flag, uv_flag}), .q(flag_s)
  );

  bg_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_en (
    .clk(clk), .rst(rst), .d(en_n), .q(en_s)
  );

  bg_rise #(.W(SIDES)) u_pwm_edge (
    .clk(clk), .rst(rst), .lvl(pwm_s), .rise_any(pwm_rise)
  );

  bg_rise #(.W(1)) u_en_edge (
    .clk(clk), .rst(rst), .lvl(~en_s), .rise_any(en_fall)
  );

  bg_latch_ctl u_lat (
    .clk(clk), .rst(rst), .cond_s(|flag_s[3:1]), .en_fall(en_fall),
    .pwm_rise(pwm_rise), .st(lat_st)
  );

  bg_uv_ctl u_uv (
    .clk(clk), .rst(rst), .uv_s(flag_s[0]), .pwm_rise(pwm_rise), .st(uv_st)
  );

  assign lat_raw = ot_flag | oc_flag | mute_req;
  assign off_ov  = lat_raw | (lat_st != LAT_IDLE);
  assign uv_ov   = uv_flag | (uv_st != UV_OK);
  assign flt_n   = ~(lat_raw | (lat_st == LAT_HELD));

  bg_outstage #(.SIDES(SIDES)) u_out (
    .clk(clk), .rst(rst), .pwm_s(pwm_s), .off_ov(off_ov), .uv_ov(uv_ov),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .hiz(hiz)
  );

endmodule

// File: rtl/bridge_guard_chk.sv
module bridge_guard_chk #(
  parameter int SIDES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             uv_flag,
  input logic             ot_flag,
  input logic             oc_flag,
  input logic             mute_req,
  input logic [SIDES-1:0] gate_hi,
  input logic [SIDES-1:0] gate_lo,
  input logic [SIDES-1:0] hiz,
  input logic             flt_n
);

  // R2
  uv_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (uv_flag && hiz == '0) |-> (gate_hi == '0 && gate_lo == '1 && flt_n));

  // R4
  fault_float_chk: assert property (@(posedge clk) disable iff (rst)
    (ot_flag || oc_flag || mute_req) |-> (gate_hi == '0 && gate_lo == '0 && hiz == '1 && !flt_n));

  // R7
  report_floats_chk: assert property (@(posedge clk) disable iff (rst)
    !flt_n |-> (hiz == '1 && gate_hi == '0 && gate_lo == '0));

  // R1
  no_shoot_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_hi & gate_lo) == '0);

  // R8
  resume_clean_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_hi[0]) |-> (!uv_flag && !ot_flag && !oc_flag && !mute_req && hiz == '0));

  // R9
  overlap_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (uv_flag && !flt_n) |-> (gate_lo == '0));

endmodule

bind bridge_guard bridge_guard_chk #(.SIDES(SIDES)) u_chk (
  .clk(clk), .rst(rst), .uv_flag(uv_flag), .ot_flag(ot_flag), .oc_flag(oc_flag),
  .mute_req(mute_req), .gate_hi(gate_hi), .gate_lo(gate_lo), .hiz(hiz), .flt_n(flt_n)
);

// File: tb/bridge_guard_test.sv
module bridge_guard_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] pwm_in = 2'b00;
  logic       uv_flag = 1'b0, ot_flag = 1'b0, oc_flag = 1'b0, mute_req = 1'b0;
  logic       en_n = 1'b1;
  logic [1:0] gate_hi, gate_lo, hiz;
  logic       flt_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // packed view: {flt_n, hiz[1:0], gate_lo[1:0], gate_hi[1:0]}
  localparam logic [6:0] CLAMP   = 7'b1_00_11_00;
  localparam logic [6:0] FLT_HLD = 7'b0_11_00_00;
  localparam logic [6:0] FLT_ARM = 7'b1_11_00_00;

  bridge_guard #(.SIDES(2), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .pwm_in(pwm_in), .uv_flag(uv_flag), .ot_flag(ot_flag),
    .oc_flag(oc_flag), .mute_req(mute_req), .en_n(en_n),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .hiz(hiz), .flt_n(flt_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [6:0] normal(input logic [1:0] p);
    return {1'b1, 2'b00, ~p, p};
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [6:0] exp);
    logic [6:0] act;
    act = {flt_n, hiz, gate_lo, gate_hi};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic en_pulse();
    en_n = 1'b0;
    cyc(6);
    en_n = 1'b1;
    cyc(6);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    cyc(4);
    check("R1 in reset", CLAMP);
    rst = 1'b0;
    cyc(4);
    check("R1 after reset", normal(2'b00));
    pwm_in = 2'b01; cyc(4);
    check("R1 side A high", normal(2'b01));
    pwm_in = 2'b10; cyc(4);
    check("R1 side B high", normal(2'b10));
  endtask

  task automatic t_uv();
    pwm_in = 2'b11; cyc(4);
    check("R1 both high", normal(2'b11));
    uv_flag = 1'b1; #1;
    check("R2 immediate clamp", CLAMP);
    cyc(5);
    check("R2 clamp held", CLAMP);
    pwm_in = 2'b00; cyc(3);
    pwm_in = 2'b11; cyc(3);
    check("R2 pwm ignored", CLAMP);
    pwm_in = 2'b00;
    uv_flag = 1'b0;
    cyc(8);
    check("R3 waits for edge", CLAMP);
    pwm_in = 2'b10; cyc(5);
    check("R3 resume side B", normal(2'b10));
    pwm_in = 2'b00; cyc(4);
  endtask

  task automatic t_latched();
    oc_flag = 1'b1; #1;
    check("R4 oc immediate", FLT_HLD);
    cyc(4);
    oc_flag = 1'b0; cyc(6);
    check("R5 oc latched", FLT_HLD);
    pwm_in = 2'b01; cyc(3);
    pwm_in = 2'b00; cyc(3);
    check("R8 edge while held", FLT_HLD);
    ot_flag = 1'b1; #1;
    check("R4 ot immediate", FLT_HLD);
    cyc(4);
    en_pulse();
    check("R6 clear during ot", FLT_HLD);
    ot_flag = 1'b0; cyc(6);
    check("R6 needs new clear", FLT_HLD);
    pwm_in = 2'b01; cyc(4);
    en_pulse();
    check("R7 report released", FLT_ARM);
    cyc(10);
    check("R8 high level no resume", FLT_ARM);
    pwm_in = 2'b00; cyc(4);
    check("R8 falling no resume", FLT_ARM);
    pwm_in = 2'b01; cyc(5);
    check("R8 resume side A", normal(2'b01));
  endtask

  task automatic t_mute();
    mute_req = 1'b1; #1;
    check("R10 mute floats", FLT_HLD);
    cyc(4);
    en_pulse();
    check("R10 clear ignored while muted", FLT_HLD);
    mute_req = 1'b0; cyc(6);
    check("R10 latched after release", FLT_HLD);
    en_pulse();
    check("R10 report released", FLT_ARM);
    pwm_in = 2'b11; cyc(5);
    check("R10 resume", normal(2'b11));
    pwm_in = 2'b00; cyc(4);
  endtask

  task automatic t_overlap();
    uv_flag = 1'b1; oc_flag = 1'b1; #1;
    check("R9 float wins", FLT_HLD);
    cyc(4);
    uv_flag = 1'b0; cyc(6);
    check("R9 uv recovery keeps latch", FLT_HLD);
    pwm_in = 2'b01; cyc(3);
    pwm_in = 2'b00; cyc(3);
    check("R9 edge keeps latch", FLT_HLD);
    oc_flag = 1'b0; cyc(6);
    check("R9 still latched", FLT_HLD);
    en_pulse();
    check("R9 cleared float", FLT_ARM);
    pwm_in = 2'b10; cyc(5);
    check("R9 joint resume", normal(2'b10));
    pwm_in = 2'b00; cyc(4);
    uv_flag = 1'b1; oc_flag = 1'b1; cyc(4);
    oc_flag = 1'b0; cyc(6);
    en_pulse();
    pwm_in = 2'b01; cyc(5);
    check("R9 clamp after latch release", CLAMP);
    uv_flag = 1'b0; cyc(8);
    check("R3 clamp until edge", CLAMP);
    pwm_in = 2'b00; cyc(3);
    pwm_in = 2'b01; cyc(5);
    check("R3 resume after overlap", normal(2'b01));
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_uv();
    t_latched();
    t_mute();
    t_overlap();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule